// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Controller

This block gathers the event pulses a DMA engine raises (one completion event and five error events) into a latched status word. A single-cycle pulse on any source sets its status bit, and the bit stays set until software clears it. The status word is ANDed with an enable word to form the cause word. The cause word then drives one of two delivery paths. The first is a level interrupt wire. The second is a one-cycle message pulse that carries the cause word.

Software reaches the block through a simple register port. Writes are qualified by `reg_we` and reads are combinational on `reg_addr`. The status word reads at 0x100. The write-one-to-clear register is at 0x108 and the enable word at 0x110. The delivery-mode register at 0x004 keeps a 4-bit field, and its bit 0 selects the wire (1) or message (0) path.

Delivery is run by a four-state machine:
- `ST_QUIET`: the cause word is zero.
- `ST_WIRE`: the wire is asserted.
- `ST_MSG_FIRE`: a message pulse is being emitted.
- `ST_MSG_HOLD`: a message has been sent and the cause is still non-zero.

The transitions are:
- QUIET→WIRE: cause non-zero in wire mode.
- QUIET→MSG_FIRE: cause non-zero in message mode.
- MSG_FIRE→MSG_HOLD: cause remains, message mode.
- MSG_FIRE/MSG_HOLD→WIRE: mode switched to wire.
- WIRE→MSG_HOLD: mode switched to message while the cause remains.
- Any state→QUIET: the cause word is zero.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset the status word and the enable word read 0, the mode register reads 0x1 (wire mode), and `irq_line` and `msg_valid` are low.
- R2: A pulse on `evt_in[i]` sets one status bit, which stays set until cleared. The mapping is i=0→bit 0 (completion), i=1→bit 1, i=2→bit 9, i=3→bit 10, i=4→bit 11 and i=5→bit 14.
- R3: Status bits with no source always read 0. Writes to the status address have no effect. The enable word stores and reads back only the six assigned bit positions.
- R4: A write to 0x108 clears exactly the status bits that are 1 in the written data. All other bits keep their value.
- R5: When a source pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R6: The cause word is status AND enable. With the enable word at 0, status bits still latch but neither output is driven.
- R7: In wire mode, `irq_line` rises one cycle after the cause word becomes non-zero. It stays high while any cause bit remains and falls one cycle after the cause word returns to zero.
- R8: In message mode, `msg_valid` pulses for exactly one cycle, one cycle after the cause word goes from zero to non-zero. During that pulse `msg_cause` carries the cause word. No further pulse occurs until the cause word has returned to zero.
- R9: The mode register at 0x004 stores and reads back only data bits 3:0. Upper bits read 0.
- R10: `irq_line` is never high unless wire mode was selected in the previous cycle. `msg_valid` and `irq_line` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 6 | Source event pulses (completion, then five error sources) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_line | output | 1 | Level interrupt (wire mode) |
| msg_valid | output | 1 | One-cycle interrupt message strobe (message mode) |
| msg_cause | output | 32 | Cause word carried with the message, zero otherwise |

## Verification
The assertions check several properties on every cycle:
- unassigned status bits stay zero;
- status bits only fall on a clear, and a set wins over a same-cycle clear;
- the wire falls one cycle after the cause empties;
- each message follows a zero cause two cycles earlier and carries the previous cycle's cause;
- the two delivery paths are exclusive.

Only the bench scenarios can show the rest:
- the exact source-to-bit mapping;
- the register address decode and read-back masking;
- that a masked status produces no output until enabled;
- that a second source arriving during an open cause sends no extra message.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_SRC = 6;

    // status bit positions, source 0 is the completion event
    localparam int SRC_POS [NUM_SRC] = '{0, 1, 9, 10, 11, 14};

    localparam logic [11:0] ADDR_MODE   = 12'h004;
    localparam logic [11:0] ADDR_STATUS = 12'h100;
    localparam logic [11:0] ADDR_CLEAR  = 12'h108;
    localparam logic [11:0] ADDR_ENABLE = 12'h110;

    localparam int          MODE_W     = 4;
    localparam logic [3:0]  MODE_RESET = 4'h1;

    function automatic logic [WORD_W-1:0] build_impl_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[SRC_POS[i]] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [WORD_W-1:0] IMPL_MASK = build_impl_mask();

    typedef enum logic [1:0] {
        ST_QUIET    = 2'd0,
        ST_WIRE     = 2'd1,
        ST_MSG_FIRE = 2'd2,
        ST_MSG_HOLD = 2'd3
    } deliv_state_t;

endpackage

// File: rtl/dmairq_status.sv
module dmairq_status
    import dmairq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     evt_in,
    input  logic [WORD_W-1:0]      clr_mask,
    output logic [WORD_W-1:0]      set_mask,
    output logic [WORD_W-1:0]      status_q
);

    logic [WORD_W-1:0] status_d;

    // scatter the source pulses onto their sparse bit positions
    always_comb begin
        set_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            set_mask[SRC_POS[i]] = evt_in[i];
        end
    end

    // set has priority over a clear arriving in the same cycle
    always_comb begin
        status_d = ((status_q & ~clr_mask) | set_mask) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/dmairq_regs.sv
module dmairq_regs
    import dmairq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    input  logic [WORD_W-1:0]      status_q,
    output logic [WORD_W-1:0]      enable_q,
    output logic [MODE_W-1:0]      mode_q,
    output logic [WORD_W-1:0]      clr_mask,
    output logic [WORD_W-1:0]      reg_rdata
);

    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(ADDR_CLEAR);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ADDR_ENABLE);

    logic hit_mode;
    logic hit_clear;
    logic hit_enable;

    always_comb begin
        hit_mode   = reg_we && (reg_addr == A_MODE);
        hit_clear  = reg_we && (reg_addr == A_CLEAR);
        hit_enable = reg_we && (reg_addr == A_ENABLE);
        clr_mask   = hit_clear ? (reg_wdata & IMPL_MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            mode_q   <= MODE_RESET;
        end else begin
            if (hit_enable) begin
                enable_q <= reg_wdata & IMPL_MASK;
            end
            if (hit_mode) begin
                mode_q <= reg_wdata[MODE_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_STATUS: reg_rdata = status_q;
            A_ENABLE: reg_rdata = enable_q;
            A_MODE:   reg_rdata = {{(WORD_W-MODE_W){1'b0}}, mode_q};
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmairq_fsm.sv
module dmairq_fsm
    import dmairq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WORD_W-1:0]      cause_word,
    input  logic                   wired_sel,
    output logic                   irq_line,
    output logic                   msg_valid,
    output logic [WORD_W-1:0]      msg_cause
);

    deliv_state_t      state_q;
    deliv_state_t      state_d;
    logic [WORD_W-1:0] msg_word_q;
    logic              any_cause;

    assign any_cause = |cause_word;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (any_cause) begin
                    state_d = wired_sel ? ST_WIRE : ST_MSG_FIRE;
                end
            end
            ST_MSG_FIRE, ST_MSG_HOLD, ST_WIRE: begin
                if (!any_cause) begin
                    state_d = ST_QUIET;
                end else if (wired_sel) begin
                    state_d = ST_WIRE;
                end else begin
                    state_d = ST_MSG_HOLD;
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    // state register plus the cause snapshot taken on the message launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_QUIET;
            msg_word_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_QUIET && state_d == ST_MSG_FIRE) begin
                msg_word_q <= cause_word;
            end
        end
    end

    always_comb begin
        irq_line  = 1'b0;
        msg_valid = 1'b0;
        msg_cause = '0;
        unique case (state_q)
            ST_WIRE:     irq_line = 1'b1;
            ST_MSG_FIRE: begin
                msg_valid = 1'b1;
                msg_cause = msg_word_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     evt_in,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    output logic                   irq_line,
    output logic                   msg_valid,
    output logic [WORD_W-1:0]      msg_cause
);

    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] enable_word;
    logic [WORD_W-1:0] set_mask;
    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] cause_word;
    logic [MODE_W-1:0] mode_word;
    logic              wired_sel;

    dmairq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .clr_mask (clr_mask),
        .set_mask (set_mask),
        .status_q (status_word)
    );

    dmairq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_q  (status_word),
        .enable_q  (enable_word),
        .mode_q    (mode_word),
        .clr_mask  (clr_mask),
        .reg_rdata (reg_rdata)
    );

    assign cause_word = status_word & enable_word;
    assign wired_sel  = mode_word[0];

    dmairq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cause_word (cause_word),
        .wired_sel  (wired_sel),
        .irq_line   (irq_line),
        .msg_valid  (msg_valid),
        .msg_cause  (msg_cause)
    );

endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk
    import dmairq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] status_word,
    input logic [WORD_W-1:0] set_mask,
    input logic [WORD_W-1:0] clr_mask,
    input logic [WORD_W-1:0] cause_word,
    input logic              wired_sel,
    input logic              irq_line,
    input logic              msg_valid,
    input logic [WORD_W-1:0] msg_cause
);

    p_unassigned_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & ~IMPL_MASK) == '0);

    p_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status_word & $past(status_word)) == $past(status_word)));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((status_word & $past(set_mask)) == $past(set_mask)));

    p_clear_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((status_word & $past(clr_mask & ~set_mask)) == '0));

    p_wire_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_word == '0) |=> !irq_line);

    p_msg_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    p_msg_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(cause_word, 2) == '0));

    p_msg_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_cause == $past(cause_word)));

    p_wire_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line |-> $past(wired_sel));

    p_one_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_line && msg_valid));

endmodule

bind dmairq_ctrl dmairq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_word (status_word),
    .set_mask    (set_mask),
    .clr_mask    (clr_mask),
    .cause_word  (cause_word),
    .wired_sel   (wired_sel),
    .irq_line    (irq_line),
    .msg_valid   (msg_valid),
    .msg_cause   (msg_cause)
);

// File: tb/dmairq_ctrl_bench.sv
`timescale 1ns/1ps
module dmairq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_in = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_line;
    logic        msg_valid;
    logic [31:0] msg_cause;

    int n_checks = 0;
    int n_fail   = 0;
    int n_msgs   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dmairq_ctrl u_dmairq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_line  (irq_line),
        .msg_valid (msg_valid),
        .msg_cause (msg_cause)
    );

    always @(negedge clk) if (rst_n && msg_valid) n_msgs++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h100, d); chk("R1 status", d, 32'h0);
        rd(12'h110, d); chk("R1 enable", d, 32'h0);
        rd(12'h004, d); chk("R1 mode", d, 32'h1);
        chk("R1 irq_line", {31'b0, irq_line}, 32'h0);
        chk("R1 msg_valid", {31'b0, msg_valid}, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(6'b000001); rd(12'h100, d); chk("R2 src0->bit0", d, 32'h0001);
        pulse(6'b000100); rd(12'h100, d); chk("R2 src2->bit9", d, 32'h0201);
        pulse(6'b111010); idle(3);
        rd(12'h100, d); chk("R2 all sources latched", d, 32'h4E03);
        chk("R6 no wire with enable 0", {31'b0, irq_line}, 32'h0);
    endtask

    task automatic t_unassigned();
        logic [31:0] d;
        wr(12'h100, 32'h0);
        rd(12'h100, d); chk("R3 status write ignored", d, 32'h4E03);
        wr(12'h110, 32'hFFFF_FFFF);
        rd(12'h110, d); chk("R3 enable assigned bits only", d, 32'h4E03);
        wr(12'h110, 32'h0);
        idle(2);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(12'h108, 32'h0000_0201);
        rd(12'h100, d); chk("R4 partial clear", d, 32'h4C02);
        wr(12'h108, 32'hFFFF_FFFF);
        rd(12'h100, d); chk("R4 full clear", d, 32'h0);
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        @(negedge clk);
        evt_in = 6'b000001; reg_we = 1'b1; reg_addr = 12'h108; reg_wdata = 32'h1;
        @(negedge clk);
        evt_in = '0; reg_we = 1'b0; reg_wdata = '0;
        rd(12'h100, d); chk("R5 set beats clear", d, 32'h1);
        wr(12'h108, 32'h1);
    endtask

    task automatic t_mask();
        pulse(6'b000100); idle(3);
        chk("R6 masked bit no wire", {31'b0, irq_line}, 32'h0);
        wr(12'h110, 32'h0000_0200);
        chk("R6 wire not yet", {31'b0, irq_line}, 32'h0);
        @(negedge clk);
        chk("R6 wire after enable", {31'b0, irq_line}, 32'h1);
        wr(12'h108, 32'h200);
        idle(2);
        chk("R6 wire gone after clear", {31'b0, irq_line}, 32'h0);
    endtask

    task automatic t_wired();
        wr(12'h110, 32'h4E03);
        pulse(6'b001000);
        chk("R7 wire one cycle later", {31'b0, irq_line}, 32'h0);
        @(negedge clk);
        chk("R7 wire rises", {31'b0, irq_line}, 32'h1);
        idle(3);
        chk("R7 wire held", {31'b0, irq_line}, 32'h1);
        chk("R10 no message in wire mode", {31'b0, msg_valid}, 32'h0);
        wr(12'h108, 32'h400);
        chk("R7 wire until next edge", {31'b0, irq_line}, 32'h1);
        @(negedge clk);
        chk("R7 wire falls", {31'b0, irq_line}, 32'h0);
    endtask

    task automatic t_msg();
        int base;
        wr(12'h004, 32'h0);
        base = n_msgs;
        pulse(6'b000010);
        chk("R8 no message yet", {31'b0, msg_valid}, 32'h0);
        @(negedge clk);
        chk("R8 message strobe", {31'b0, msg_valid}, 32'h1);
        chk("R8 message cause", msg_cause, 32'h2);
        @(negedge clk);
        chk("R8 strobe single", {31'b0, msg_valid}, 32'h0);
        pulse(6'b000001); idle(4);
        chk("R8 no repeat while cause open", n_msgs - base, 32'd1);
        chk("R10 no wire in message mode", {31'b0, irq_line}, 32'h0);
        wr(12'h108, 32'h3); idle(2);
        pulse(6'b100000);
        @(negedge clk);
        chk("R8 second message cause", msg_cause, 32'h4000);
        idle(2);
        chk("R8 two messages total", n_msgs - base, 32'd2);
        wr(12'h108, 32'h4000);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(12'h004, 32'hFFFF_FFF6);
        rd(12'h004, d); chk("R9 mode low nibble", d, 32'h6);
        wr(12'h004, 32'hABCD_0011);
        rd(12'h004, d); chk("R9 mode readback", d, 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_unassigned();
        t_clear();
        t_setwins();
        t_mask();
        t_wired();
        t_msg();
        t_mode();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule